// File: doc/BRIEF.md
# Microcoded Sequential FIR Filter

This block is a seven-tap finite impulse response filter that reuses one 8x8 signed multiplier and one 16-bit adder for every tap. The schedule of multiply-accumulate steps is not a hand-written state machine. A small microsequencer fetches one microword per cycle from a control store, and each field of that word drives one datapath control: coefficient-write permission, the coefficient and tap operand selects, product gating, accumulator load and clear, delay-line shift, a wait-for-sample flag, result publication and the next address. The control store is computed at elaboration from the tap count, so regenerating it retargets the schedule without touching the datapath.

The host first writes up to four coefficient words while the filter is idle. The taps use a symmetric set: tap k multiplies by coefficient index min(k, 6-k). After that it streams samples with a valid/ready handshake. Each accepted sample is pushed into a seven-deep delay line and the accumulator is cleared. Seven product steps then sum into the accumulator, and the total is published on the output with a one-cycle done strobe. While a result is being computed, the ready output is low, and any offered sample or coefficient write is dropped.

Top module: `fir_ucode_mac`

## Requirements
- R1: While reset is applied and in the first cycle after it is released, `smp_ready` is 1, `y_done` is 0 and `y_out` is 0. Coefficients and delay-line entries reset to 0.
- R2: For each accepted sample, `y_out` equals the low 16 bits of sum over k=0..6 of c[min(k,6-k)] * x[n-k]. Here x[n] is the newest accepted sample, x[n-k] is the sample accepted k acceptances earlier (0 if there is none), and all values are two's-complement signed 8-bit.
- R3: `y_done` goes to 1 exactly 8 clock edges after the edge that accepts a sample (`smp_valid` and `smp_ready` both 1), and stays high for exactly one cycle.
- R4: `smp_ready` is 0 from the accepting edge until `y_done` rises. A sample offered while `smp_ready` is 0 is not stored and has no effect on any later result.
- R5: A coefficient write (`coef_we` = 1) at an edge where `smp_ready` is 1 stores `coef_data` into coefficient `coef_idx` (index 0..3). A write made while `smp_ready` is 0 is ignored.
- R6: The accumulator is 16 bits wide and wraps modulo 2^16 on overflow, with no saturation.
- R7: `y_out` holds its value in every cycle in which `y_done` is 0.
- R8: `smp_ready` is 1 in the cycle in which `y_done` is 1, so a new sample can be accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample offered this cycle |
| smp_data | input | 8 | Signed input sample |
| smp_ready | output | 1 | Filter idle and able to take a sample |
| coef_we | input | 1 | Coefficient write request |
| coef_idx | input | 2 | Coefficient index written |
| coef_data | input | 8 | Signed coefficient value |
| y_out | output | 16 | Signed filter result, wrapped to 16 bits |
| y_done | output | 1 | One-cycle strobe marking a new result |

## Verification
Only one result is ever due, and it arrives eight edges after the accepting edge. The bench counts those edges itself and samples at the falling edge that follows the eighth, where `y_done` and `y_out` must both match the reference convolution. It also checks that `y_done` is still low one cycle earlier and low again one cycle later, and that `y_out` is unchanged then. Samples and coefficient writes offered during the busy window leave later results unchanged, because the bench's reference model never absorbs them.

// File: rtl/fir_uc_pkg.sv
package fir_uc_pkg;

   // coefficient index used by tap k of a symmetric filter of length n
   function automatic int mirror_tap(input int k, input int n);
      return (k < n - 1 - k) ? k : n - 1 - k;
   endfunction

   // number of stored coefficients for an odd symmetric filter
   function automatic int coef_count(input int n);
      return (n + 1) / 2;
   endfunction

endpackage

// File: rtl/fir_uc_rom.sv
module fir_uc_rom #(
   parameter int NTAP = 7,
   parameter int PCW  = 4,
   parameter int CSW  = 2,
   parameter int TSW  = 3
) (
   input  logic [PCW-1:0] pc,
   output logic           le,
   output logic [CSW-1:0] csel,
   output logic [TSW-1:0] tsel,
   output logic           ps,
   output logic           lacc,
   output logic           clr,
   output logic           shift,
   output logic           hold,
   output logic           done,
   output logic [PCW-1:0] nxt
);
   localparam int DEPTH   = 2 ** PCW;
   localparam int FINISH  = NTAP + 1;

   typedef struct packed {
      logic           le;
      logic [CSW-1:0] csel;
      logic [TSW-1:0] tsel;
      logic           ps;
      logic           lacc;
      logic           clr;
      logic           shift;
      logic           hold;
      logic           done;
      logic [PCW-1:0] nxt;
   } uword_t;

   // address 0 waits for a sample, 1..NTAP multiply-accumulate, NTAP+1 publishes
   function automatic uword_t make_uw(input int a);
      uword_t u;
      u = '0;
      if (a == 0) begin
         u.le    = 1'b1;
         u.clr   = 1'b1;
         u.shift = 1'b1;
         u.hold  = 1'b1;
         u.nxt   = PCW'(1);
      end else if (a <= NTAP) begin
         u.csel = CSW'(fir_uc_pkg::mirror_tap(a - 1, NTAP));
         u.tsel = TSW'(a - 1);
         u.ps   = 1'b1;
         u.lacc = 1'b1;
         u.nxt  = PCW'(a + 1);
      end else if (a == FINISH) begin
         u.done = 1'b1;
         u.nxt  = '0;
      end else begin
         u.nxt  = '0;
      end
      return u;
   endfunction

   uword_t store [DEPTH];
   uword_t cur;

   for (genvar a = 0; a < DEPTH; a++) begin : g_word
      assign store[a] = make_uw(a);
   end

   assign cur   = store[pc];
   assign le    = cur.le;
   assign csel  = cur.csel;
   assign tsel  = cur.tsel;
   assign ps    = cur.ps;
   assign lacc  = cur.lacc;
   assign clr   = cur.clr;
   assign shift = cur.shift;
   assign hold  = cur.hold;
   assign done  = cur.done;
   assign nxt   = cur.nxt;
endmodule

// File: rtl/fir_uc_seq.sv
module fir_uc_seq #(
   parameter int NTAP = 7,
   parameter int PCW  = 4,
   parameter int CSW  = 2,
   parameter int TSW  = 3
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           smp_valid,
   output logic           ready,
   output logic           accept,
   output logic           coef_ok,
   output logic [CSW-1:0] csel,
   output logic [TSW-1:0] tsel,
   output logic           ps,
   output logic           lacc,
   output logic           clr_go,
   output logic           shift_go,
   output logic           publish
);
   logic [PCW-1:0] pc;
   logic [PCW-1:0] nxt;
   logic           le, clr, shift, hold, done;

   fir_uc_rom #(.NTAP(NTAP), .PCW(PCW), .CSW(CSW), .TSW(TSW)) u_rom (
      .pc(pc), .le(le), .csel(csel), .tsel(tsel), .ps(ps), .lacc(lacc),
      .clr(clr), .shift(shift), .hold(hold), .done(done), .nxt(nxt)
   );

   assign ready    = hold;
   assign accept   = hold & smp_valid;
   assign coef_ok  = le;
   assign clr_go   = clr & accept;
   assign shift_go = shift & accept;
   assign publish  = done;

   always_ff @(posedge clk) begin
      if (rst)
         pc <= '0;
      else if (hold && !smp_valid)
         pc <= pc;
      else
         pc <= nxt;
   end
endmodule

// File: rtl/fir_uc_datapath.sv
module fir_uc_datapath #(
   parameter int DW   = 8,
   parameter int NTAP = 7,
   parameter int CSW  = 2,
   parameter int TSW  = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [DW-1:0]   smp_data,
   input  logic            coef_we,
   input  logic [CSW-1:0]  coef_idx,
   input  logic [DW-1:0]   coef_data,
   input  logic            coef_ok,
   input  logic [CSW-1:0]  csel,
   input  logic [TSW-1:0]  tsel,
   input  logic            ps,
   input  logic            lacc,
   input  logic            clr_go,
   input  logic            shift_go,
   input  logic            publish,
   output logic [2*DW-1:0] y_out,
   output logic            y_done
);
   localparam int NCOEF = fir_uc_pkg::coef_count(NTAP);
   localparam int AW    = 2 * DW;

   logic [DW-1:0] coef [NCOEF];
   logic [DW-1:0] dline [NTAP];
   logic [DW-1:0] op_c, op_x;
   logic [AW-1:0] prod, acc, y_q;
   logic          done_q;

   for (genvar i = 0; i < NCOEF; i++) begin : g_coef
      always_ff @(posedge clk) begin
         if (rst)
            coef[i] <= '0;
         else if (coef_we && coef_ok && coef_idx == CSW'(i))
            coef[i] <= coef_data;
      end
   end

   for (genvar t = 0; t < NTAP; t++) begin : g_dline
      if (t == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (rst)           dline[t] <= '0;
            else if (shift_go) dline[t] <= smp_data;
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (rst)           dline[t] <= '0;
            else if (shift_go) dline[t] <= dline[t-1];
         end
      end
   end

   always_comb begin
      op_c = '0;
      for (int i = 0; i < NCOEF; i++)
         if (csel == CSW'(i)) op_c = coef[i];
   end

   always_comb begin
      op_x = '0;
      for (int t = 0; t < NTAP; t++)
         if (tsel == TSW'(t)) op_x = dline[t];
   end

   always_comb begin
      if (ps)
         prod = $signed({{DW{op_c[DW-1]}}, op_c}) * $signed({{DW{op_x[DW-1]}}, op_x});
      else
         prod = '0;
   end

   always_ff @(posedge clk) begin
      if (rst)         acc <= '0;
      else if (clr_go) acc <= '0;
      else if (lacc)   acc <= acc + prod;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         y_q    <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= publish;
         if (publish) y_q <= acc;
      end
   end

   assign y_out  = y_q;
   assign y_done = done_q;
endmodule

// File: rtl/fir_ucode_mac.sv
module fir_ucode_mac #(
   parameter int  DW    = 8,
   parameter int  NTAP  = 7,
   localparam int NCOEF = (NTAP + 1) / 2,
   localparam int CSW   = (NCOEF > 1) ? $clog2(NCOEF) : 1,
   localparam int TSW   = $clog2(NTAP),
   localparam int PCW   = $clog2(NTAP + 2)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            smp_valid,
   input  logic [DW-1:0]   smp_data,
   output logic            smp_ready,
   input  logic            coef_we,
   input  logic [CSW-1:0]  coef_idx,
   input  logic [DW-1:0]   coef_data,
   output logic [2*DW-1:0] y_out,
   output logic            y_done
);
   if (NTAP % 2 == 0 || NTAP < 3) begin : g_bad_ntap
      $error("tap count must be odd and at least 3");
   end
   if (DW < 2) begin : g_bad_dw
      $error("sample width must be at least 2");
   end

   logic           accept, coef_ok, ps, lacc, clr_go, shift_go, publish;
   logic [CSW-1:0] csel;
   logic [TSW-1:0] tsel;

   fir_uc_seq #(.NTAP(NTAP), .PCW(PCW), .CSW(CSW), .TSW(TSW)) u_seq (
      .clk(clk), .rst(rst), .smp_valid(smp_valid), .ready(smp_ready),
      .accept(accept), .coef_ok(coef_ok), .csel(csel), .tsel(tsel),
      .ps(ps), .lacc(lacc), .clr_go(clr_go), .shift_go(shift_go),
      .publish(publish)
   );

   fir_uc_datapath #(.DW(DW), .NTAP(NTAP), .CSW(CSW), .TSW(TSW)) u_dp (
      .clk(clk), .rst(rst), .smp_data(smp_data), .coef_we(coef_we),
      .coef_idx(coef_idx), .coef_data(coef_data), .coef_ok(coef_ok),
      .csel(csel), .tsel(tsel), .ps(ps), .lacc(lacc), .clr_go(clr_go),
      .shift_go(shift_go), .publish(publish), .y_out(y_out), .y_done(y_done)
   );

   logic unused_accept;
   assign unused_accept = accept;
endmodule

// File: rtl/fir_ucode_mac_chk.sv
module fir_ucode_mac_chk #(
   parameter int DW   = 8,
   parameter int NTAP = 7
) (
   input logic            clk,
   input logic            rst,
   input logic            smp_valid,
   input logic            smp_ready,
   input logic [2*DW-1:0] y_out,
   input logic            y_done
);
   localparam int CW     = $clog2(NTAP + 4) + 1;
   localparam int DUE_AT = NTAP + 2;

   logic [CW-1:0] since;

   always_ff @(posedge clk) begin
      if (rst)                        since <= '0;
      else if (smp_valid && smp_ready) since <= CW'(1);
      else if (y_done)                since <= '0;
      else if (since != '0)           since <= since + CW'(1);
   end

   a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (smp_ready && !y_done && y_out == '0));

   a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
      y_done |=> !y_done);

   a_r3_latency: assert property (@(posedge clk) disable iff (rst)
      y_done |-> since == CW'(DUE_AT));

   a_r4_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
      (smp_valid && smp_ready) |=> !smp_ready);

   a_r7_hold_result: assert property (@(posedge clk) disable iff (rst)
      !y_done |-> $stable(y_out));

   a_r8_ready_with_done: assert property (@(posedge clk) disable iff (rst)
      y_done |-> smp_ready);
endmodule

bind fir_ucode_mac fir_ucode_mac_chk #(.DW(DW), .NTAP(NTAP)) u_chk (
   .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ready(smp_ready),
   .y_out(y_out), .y_done(y_done)
);

// File: tb/tb_fir_ucode_mac.sv
module tb_fir_ucode_mac;
   localparam int CLK_PERIOD = 10;
   localparam int NT = 7;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        smp_valid = 1'b0;
   logic [7:0]  smp_data = '0;
   logic        smp_ready;
   logic        coef_we = 1'b0;
   logic [1:0]  coef_idx = '0;
   logic [7:0]  coef_data = '0;
   logic [15:0] y_out;
   logic        y_done;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   logic signed [7:0] w_m  [4];
   logic signed [7:0] hist [NT];

   always #(CLK_PERIOD/2) clk = ~clk;

   fir_ucode_mac dut (
      .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
      .smp_ready(smp_ready), .coef_we(coef_we), .coef_idx(coef_idx),
      .coef_data(coef_data), .y_out(y_out), .y_done(y_done)
   );

   function automatic int mir(input int k);
      return (k < NT - 1 - k) ? k : NT - 1 - k;
   endfunction

   function automatic logic [15:0] ref_y();
      int s = 0;
      for (int k = 0; k < NT; k++)
         s += int'(w_m[mir(k)]) * int'(hist[k]);
      return s[15:0];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_up();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   task automatic write_coef(input int idx, input logic [7:0] v);
      @(negedge clk);
      coef_we = 1'b1; coef_idx = 2'(idx); coef_data = v;
      @(posedge clk);
      w_m[idx] = v;
      @(negedge clk);
      coef_we = 1'b0;
   endtask

   // send one sample; junk=1 pokes samples and coefficient writes while busy
   task automatic send(input logic [7:0] x, input bit junk);
      logic [15:0] exp, held;
      @(negedge clk);
      while (!smp_ready) @(negedge clk);
      smp_valid = 1'b1; smp_data = x;
      @(posedge clk);
      for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      exp = ref_y();
      @(negedge clk);
      smp_valid = 1'b0;
      check("R4 ready low after accept", 32'(smp_ready), 32'd0);
      if (junk) begin
         smp_valid = 1'b1; smp_data = 8'($urandom);
         coef_we = 1'b1; coef_idx = 2'($urandom); coef_data = 8'($urandom);
      end
      for (int c = 1; c <= 8; c++) begin
         @(posedge clk);
         @(negedge clk);
         if (c == 3) begin smp_valid = 1'b0; coef_we = 1'b0; end
         if (c == 7) check("R3 no early done", 32'(y_done), 32'd0);
      end
      check("R3 done due", 32'(y_done), 32'd1);
      check("R2 result", 32'(y_out), 32'(exp));
      check("R8 ready with done", 32'(smp_ready), 32'd1);
      held = y_out;
      @(negedge clk);
      check("R3 single pulse", 32'(y_done), 32'd0);
      check("R7 result held", 32'(y_out), 32'(held));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_up();
   end

   initial begin
      void'($urandom(32'd20240417));
      for (int i = 0; i < 4; i++) w_m[i] = '0;
      for (int k = 0; k < NT; k++) hist[k] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 ready in reset", 32'(smp_ready), 32'd1);
      check("R1 done in reset", 32'(y_done), 32'd0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 y_out after reset", 32'(y_out), 32'd0);
      check("R1 done after reset", 32'(y_done), 32'd0);

      // R1: reset coefficients are zero, so the first result is zero
      send(8'd55, 1'b0);
      check("R1 zero coefs give zero", 32'(y_out), 32'd0);

      // R5: coefficient writes while idle; impulse shows symmetric taps (R2)
      write_coef(0, 8'd3); write_coef(1, 8'hFB); write_coef(2, 8'd7); write_coef(3, 8'd11);
      send(8'd1, 1'b0);
      for (int k = 0; k < NT; k++) send(8'd0, 1'b0);

      // R4/R5: busy-time samples and coefficient writes must not change results
      for (int n = 0; n < 10; n++) send(8'($urandom), 1'b1);

      // R6: overflow wraps at 16 bits
      for (int i = 0; i < 4; i++) write_coef(i, 8'h80);
      for (int n = 0; n < NT; n++) send(8'h80, 1'b0);
      check("R6 wrapped sum", 32'(y_out), 32'h0000C000);
      for (int n = 0; n < 3; n++) send(8'h7F, 1'b0);

      // random coefficients and samples
      for (int r = 0; r < 4; r++) begin
         for (int i = 0; i < 4; i++) write_coef(i, 8'($urandom));
         for (int n = 0; n < 12; n++) send(8'($urandom), n % 3 == 0);
      end

      finish_up();
   end
endmodule